// File: doc/BRIEF.md
# Partition-Aware LRU Victim Selector

This block holds the replacement state for a small fully-associative cache that several processes share in turn. Each line keeps a valid bit, the ID of the process that filled it, a tag and a recency rank. Only one process runs at a time, and a context-switch pulse names the next one. A lookup hits only when both the tag and the owner match the running process, because processes never share an address space.

On a miss the block picks a line to refill. An invalid line is taken first. If every line is valid, the block takes the least recently used line of a process that is not running, but it skips the lines that the sleeping process keeps in reserve. Each process has a quota of reserved lines, set by software. The reserve is the process's most recently used lines, capped by its quota and by the number of lines it held when it was last switched out. When no such line is left, the block falls back to LRU among the running process's own lines. If the running process owns no line, it falls back to LRU over the whole cache.

Results come back one cycle after a request is accepted. The response is held under a valid/ready handshake. Quota writes are refused while an access is in flight, and also when the quotas would add up to more than the line count.

Top module: `lpl_victim_sel`

## Requirements
- R1: A request hits only if a valid line has an equal tag and its owner equals the running process ID. On a hit, rsp_line gives that line and rsp_evict is 0.
- R2: On a miss, if any line is invalid, the lowest-indexed invalid line is filled and rsp_evict is 0. After reset, the first LINES misses therefore fill lines 0, 1, 2, ... in order.
- R3: On a miss with every line valid, the victim is the line with the highest rank among lines that are owned by a non-running process and are not protected.
- R4: The protected lines of a non-running process p are its k most recently used valid lines, where k = min(quota of p, lines p owned when it was last switched out). A process that was never switched out has k = 0.
- R5: If R3 finds no candidate, the victim is the highest-ranked line owned by the running process. If the running process owns no line, it is the highest-ranked line in the whole cache.
- R6: Each line has a rank from 0 (most recent) to LINES-1, and the ranks always form a permutation. On an accepted request, the touched line becomes rank 0, and every line whose rank was below the touched line's old rank moves up by one.
- R7: A quota write is accepted only if req_valid and rsp_valid are both low in that cycle and the new sum of all quotas is at most LINES. A refused write leaves the quotas unchanged. quota_err is 1 after a refused write, 0 after an accepted one, and keeps its value when no write happens.
- R8: A request is accepted when req_valid and req_ready are both high. rsp_valid rises on the next cycle. While rsp_valid is high and rsp_ready is low, the response stays stable and req_ready is low.
- R9: A ctx_switch pulse loads ctx_pid into active_pid on the next cycle. It records the outgoing process's valid line count, taken before any access accepted in the same cycle, and changes no line or rank. An access accepted in the same cycle is served for the outgoing process.
- R10: After reset: all lines invalid, rank of line i equal to i, all quotas and recorded counts 0, active_pid 0, rsp_valid 0, req_ready 1, quota_err 0.
- R11: On a miss that replaces a valid line, rsp_evict is 1 and rsp_evict_pid gives that line's previous owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a request |
| req_tag | input | TAG_W | Tag to look up for the running process |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Lookup hit |
| rsp_line | output | $clog2(LINES) | Hit line, or line filled on a miss |
| rsp_evict | output | 1 | A valid line was replaced |
| rsp_evict_pid | output | $clog2(PROCS) | Owner of the replaced line |
| ctx_switch | input | 1 | Context-switch pulse |
| ctx_pid | input | $clog2(PROCS) | ID of the incoming process |
| active_pid | output | $clog2(PROCS) | Running process ID |
| quota_wr | input | 1 | Quota write strobe |
| quota_pid | input | $clog2(PROCS) | Process whose quota is written |
| quota_val | input | $clog2(LINES+1) | New quota value |
| quota_err | output | 1 | Last quota write was refused |

## Verification
A lookup and a context switch can land on the same clock edge. The bench drives both in one cycle. It then checks that the filled line belongs to the outgoing process: a lookup of the same tag by the new process must miss, and the same tag must hit again once the old process is switched back in. A quota write can also share a cycle with an accepted lookup. The bench drives that too and expects the write to be refused, while the lookup result is still checked in full. A random run mixes these collisions with ordinary traffic, and every response is compared against a reference model.

// File: rtl/lpl_pkg.sv
package lpl_pkg;
  // Which rule produced the victim of a miss.
  typedef enum logic [1:0] {
    VS_FREE    = 2'd0,
    VS_DORMANT = 2'd1,
    VS_ACTIVE  = 2'd2,
    VS_ANY     = 2'd3
  } vsrc_e;
endpackage

// File: rtl/lpl_rank_table.sv
module lpl_rank_table #(
  parameter  int LINES = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        touch_en,
  input  logic [IDX_W-1:0]            touch_idx,
  output logic [LINES-1:0][IDX_W-1:0] rank_o
);
  logic [LINES-1:0][IDX_W-1:0] rank_q, rank_d;

  always_comb begin
    rank_d = rank_q;
    for (int i = 0; i < LINES; i++) begin
      if (i == int'(touch_idx)) rank_d[i] = '0;
      else if (rank_q[i] < rank_q[touch_idx]) rank_d[i] = rank_q[i] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      rank_q <= rank_d;
    end
  end

  assign rank_o = rank_q;
endmodule

// File: rtl/lpl_line_table.sv
module lpl_line_table #(
  parameter  int LINES = 8,
  parameter  int PROCS = 4,
  parameter  int TAG_W = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int PID_W = $clog2(PROCS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fill_en,
  input  logic [IDX_W-1:0]            fill_idx,
  input  logic [PID_W-1:0]            fill_pid,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic [PID_W-1:0]            look_pid,
  input  logic [TAG_W-1:0]            look_tag,
  output logic [LINES-1:0]            valid_o,
  output logic [LINES-1:0][PID_W-1:0] owner_o,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            hit_idx_o
);
  logic [LINES-1:0]            valid_q;
  logic [LINES-1:0][PID_W-1:0] owner_q;
  logic [LINES-1:0][TAG_W-1:0] tag_q;
  logic [LINES-1:0]            match;

  // Per-line compare; owner must equal the running process.
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == look_tag) && (owner_q[g] == look_pid);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx_o = IDX_W'(i);
    end
  end
  assign hit_o = |match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (fill_en) valid_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      owner_q[fill_idx] <= fill_pid;
      tag_q[fill_idx]   <= fill_tag;
    end
  end

  assign valid_o = valid_q;
  assign owner_o = owner_q;
endmodule

// File: rtl/lpl_slice_ctrl.sv
module lpl_slice_ctrl #(
  parameter  int LINES = 8,
  parameter  int PROCS = 4,
  localparam int PID_W = $clog2(PROCS),
  localparam int CNT_W = $clog2(LINES + 1),
  localparam int SUM_W = CNT_W + PID_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ctx_switch,
  input  logic [PID_W-1:0]            ctx_pid,
  input  logic [LINES-1:0]            valid,
  input  logic [LINES-1:0][PID_W-1:0] owner,
  input  logic                        iface_idle,
  input  logic                        quota_wr,
  input  logic [PID_W-1:0]            quota_pid,
  input  logic [CNT_W-1:0]            quota_val,
  output logic [PID_W-1:0]            active_pid,
  output logic                        quota_err,
  output logic [PROCS-1:0][CNT_W-1:0] eff_cap
);
  logic [PID_W-1:0]            active_q;
  logic [PROCS-1:0][CNT_W-1:0] quota_q;
  logic [PROCS-1:0][CNT_W-1:0] held_q;
  logic                        err_q;
  logic [SUM_W-1:0]            sum_new;
  logic [CNT_W-1:0]            active_cnt;
  logic                        wr_ok;

  always_comb begin
    sum_new = '0;
    for (int p = 0; p < PROCS; p++) begin
      if (p == int'(quota_pid)) sum_new = sum_new + SUM_W'(quota_val);
      else                      sum_new = sum_new + SUM_W'(quota_q[p]);
    end
    wr_ok = quota_wr && iface_idle && (sum_new <= SUM_W'(LINES));

    active_cnt = '0;
    for (int i = 0; i < LINES; i++) begin
      if (valid[i] && (owner[i] == active_q)) active_cnt = active_cnt + 1'b1;
    end

    for (int p = 0; p < PROCS; p++) begin
      eff_cap[p] = (quota_q[p] < held_q[p]) ? quota_q[p] : held_q[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      quota_q  <= '0;
      held_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      if (ctx_switch) begin
        active_q         <= ctx_pid;
        held_q[active_q] <= active_cnt;
      end
      if (wr_ok)    quota_q[quota_pid] <= quota_val;
      if (quota_wr) err_q <= ~wr_ok;
    end
  end

  assign active_pid = active_q;
  assign quota_err  = err_q;
endmodule

// File: rtl/lpl_victim_pick.sv
module lpl_victim_pick import lpl_pkg::*; #(
  parameter  int LINES = 8,
  parameter  int PROCS = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int PID_W = $clog2(PROCS),
  localparam int CNT_W = $clog2(LINES + 1)
) (
  input  logic [LINES-1:0]            valid,
  input  logic [LINES-1:0][PID_W-1:0] owner,
  input  logic [LINES-1:0][IDX_W-1:0] rank,
  input  logic [PID_W-1:0]            active_pid,
  input  logic [PROCS-1:0][CNT_W-1:0] eff_cap,
  output logic [IDX_W-1:0]            victim_idx,
  output vsrc_e                       vsrc
);
  logic [LINES-1:0][CNT_W-1:0] own_pos;
  logic [LINES-1:0]            dorm_mask, act_mask;
  logic [IDX_W:0]              dorm_pick, act_pick, any_pick;
  logic [IDX_W-1:0]            free_idx;

  function automatic logic [IDX_W:0] pick_lru(input logic [LINES-1:0] mask,
                                              input logic [LINES-1:0][IDX_W-1:0] rk);
    logic             found;
    logic [IDX_W-1:0] best;
    found = 1'b0;
    best  = '0;
    for (int i = 0; i < LINES; i++) begin
      if (mask[i] && (!found || (rk[i] > rk[best]))) begin
        found = 1'b1;
        best  = IDX_W'(i);
      end
    end
    return {found, best};
  endfunction

  // Position of each line in its owner's recency order (0 = owner's newest).
  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      own_pos[i] = '0;
      for (int j = 0; j < LINES; j++) begin
        if (valid[j] && (owner[j] == owner[i]) && (rank[j] < rank[i]))
          own_pos[i] = own_pos[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_mask
    assign dorm_mask[g] = valid[g] && (owner[g] != active_pid) &&
                          (own_pos[g] >= eff_cap[owner[g]]);
    assign act_mask[g]  = valid[g] && (owner[g] == active_pid);
  end

  always_comb begin
    free_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
    dorm_pick = pick_lru(dorm_mask, rank);
    act_pick  = pick_lru(act_mask, rank);
    any_pick  = pick_lru(valid, rank);

    if (!(&valid)) begin
      vsrc = VS_FREE;    victim_idx = free_idx;
    end else if (dorm_pick[IDX_W]) begin
      vsrc = VS_DORMANT; victim_idx = dorm_pick[IDX_W-1:0];
    end else if (act_pick[IDX_W]) begin
      vsrc = VS_ACTIVE;  victim_idx = act_pick[IDX_W-1:0];
    end else begin
      vsrc = VS_ANY;     victim_idx = any_pick[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/lpl_victim_sel.sv
module lpl_victim_sel import lpl_pkg::*; #(
  parameter  int LINES = 8,
  parameter  int PROCS = 4,
  parameter  int TAG_W = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int PID_W = $clog2(PROCS),
  localparam int CNT_W = $clog2(LINES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TAG_W-1:0] req_tag,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_line,
  output logic             rsp_evict,
  output logic [PID_W-1:0] rsp_evict_pid,
  input  logic             ctx_switch,
  input  logic [PID_W-1:0] ctx_pid,
  output logic [PID_W-1:0] active_pid,
  input  logic             quota_wr,
  input  logic [PID_W-1:0] quota_pid,
  input  logic [CNT_W-1:0] quota_val,
  output logic             quota_err
);
  logic                        accept, iface_idle, hit;
  logic [IDX_W-1:0]            hit_idx, victim_idx, touch_idx;
  logic [LINES-1:0]            valid_vec;
  logic [LINES-1:0][PID_W-1:0] owner_vec;
  logic [LINES-1:0][IDX_W-1:0] rank_vec;
  logic [PROCS-1:0][CNT_W-1:0] eff_cap;
  vsrc_e                       vsrc;

  logic             rsp_valid_q, rsp_valid_d;
  logic             rsp_hit_q, rsp_hit_d;
  logic [IDX_W-1:0] rsp_line_q, rsp_line_d;
  logic             rsp_ev_q, rsp_ev_d;
  logic [PID_W-1:0] rsp_evp_q, rsp_evp_d;

  assign req_ready  = !rsp_valid_q || rsp_ready;
  assign accept     = req_valid && req_ready;
  assign iface_idle = !req_valid && !rsp_valid_q;
  assign touch_idx  = hit ? hit_idx : victim_idx;

  lpl_line_table #(.LINES(LINES), .PROCS(PROCS), .TAG_W(TAG_W)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_en   (accept && !hit),
    .fill_idx  (victim_idx),
    .fill_pid  (active_pid),
    .fill_tag  (req_tag),
    .look_pid  (active_pid),
    .look_tag  (req_tag),
    .valid_o   (valid_vec),
    .owner_o   (owner_vec),
    .hit_o     (hit),
    .hit_idx_o (hit_idx)
  );

  lpl_rank_table #(.LINES(LINES)) u_rank (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (accept),
    .touch_idx (touch_idx),
    .rank_o    (rank_vec)
  );

  lpl_slice_ctrl #(.LINES(LINES), .PROCS(PROCS)) u_slice (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctx_switch (ctx_switch),
    .ctx_pid    (ctx_pid),
    .valid      (valid_vec),
    .owner      (owner_vec),
    .iface_idle (iface_idle),
    .quota_wr   (quota_wr),
    .quota_pid  (quota_pid),
    .quota_val  (quota_val),
    .active_pid (active_pid),
    .quota_err  (quota_err),
    .eff_cap    (eff_cap)
  );

  lpl_victim_pick #(.LINES(LINES), .PROCS(PROCS)) u_pick (
    .valid      (valid_vec),
    .owner      (owner_vec),
    .rank       (rank_vec),
    .active_pid (active_pid),
    .eff_cap    (eff_cap),
    .victim_idx (victim_idx),
    .vsrc       (vsrc)
  );

  // Response next state.
  always_comb begin
    rsp_valid_d = accept || (rsp_valid_q && !rsp_ready);
    rsp_hit_d   = hit;
    rsp_line_d  = touch_idx;
    rsp_ev_d    = !hit && valid_vec[victim_idx];
    rsp_evp_d   = rsp_ev_d ? owner_vec[victim_idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_line_q  <= '0;
      rsp_ev_q    <= 1'b0;
      rsp_evp_q   <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (accept) begin
        rsp_hit_q  <= rsp_hit_d;
        rsp_line_q <= rsp_line_d;
        rsp_ev_q   <= rsp_ev_d;
        rsp_evp_q  <= rsp_evp_d;
      end
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_hit       = rsp_hit_q;
  assign rsp_line      = rsp_line_q;
  assign rsp_evict     = rsp_ev_q;
  assign rsp_evict_pid = rsp_evp_q;
endmodule

// File: rtl/lpl_victim_sel_chk.sv
module lpl_victim_sel_chk import lpl_pkg::*; #(
  parameter  int LINES = 8,
  parameter  int PROCS = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int PID_W = $clog2(PROCS)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        accept,
  input logic                        hit,
  input vsrc_e                       vsrc,
  input logic                        iface_idle,
  input logic [LINES-1:0][IDX_W-1:0] rank_vec,
  input logic                        req_ready,
  input logic                        rsp_valid,
  input logic                        rsp_ready,
  input logic                        rsp_hit,
  input logic [IDX_W-1:0]            rsp_line,
  input logic                        rsp_evict,
  input logic [PID_W-1:0]            rsp_evict_pid,
  input logic                        ctx_switch,
  input logic [PID_W-1:0]            ctx_pid,
  input logic [PID_W-1:0]            active_pid,
  input logic                        quota_wr,
  input logic                        quota_err
);
  logic [LINES-1:0] rank_seen;
  always_comb begin
    rank_seen = '0;
    for (int i = 0; i < LINES; i++) rank_seen[rank_vec[i]] = 1'b1;
  end

  p_hit_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit |=> rsp_hit && !rsp_evict);
  p_free_noevict_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit && (vsrc == VS_FREE) |=> !rsp_evict && !rsp_hit);
  p_dormant_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit && (vsrc == VS_DORMANT) |=> rsp_evict && (rsp_evict_pid != $past(active_pid)));
  p_active_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit && (vsrc == VS_ACTIVE) |=> rsp_evict && (rsp_evict_pid == $past(active_pid)));
  p_rank_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    &rank_seen);
  p_quota_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    quota_wr && !iface_idle |=> quota_err);
  p_rsp_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_line) && $stable(rsp_hit) && $stable(rsp_evict));
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  p_ctx_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_switch |=> active_pid == $past(ctx_pid));
  p_ctx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_switch |=> $stable(active_pid));
endmodule

bind lpl_victim_sel lpl_victim_sel_chk #(.LINES(LINES), .PROCS(PROCS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .accept        (accept),
  .hit           (hit),
  .vsrc          (vsrc),
  .iface_idle    (iface_idle),
  .rank_vec      (rank_vec),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_hit       (rsp_hit),
  .rsp_line      (rsp_line),
  .rsp_evict     (rsp_evict),
  .rsp_evict_pid (rsp_evict_pid),
  .ctx_switch    (ctx_switch),
  .ctx_pid       (ctx_pid),
  .active_pid    (active_pid),
  .quota_wr      (quota_wr),
  .quota_err     (quota_err)
);

// File: tb/lpl_victim_sel_test.sv
`timescale 1ns/1ps
module lpl_victim_sel_test;
  localparam int LINES = 8;
  localparam int PROCS = 4;
  localparam int TAG_W = 8;
  localparam int IDX_W = 3;
  localparam int PID_W = 2;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [TAG_W-1:0] req_tag = '0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_hit, rsp_evict;
  logic [IDX_W-1:0] rsp_line;
  logic [PID_W-1:0] rsp_evict_pid, active_pid;
  logic ctx_switch = 1'b0;
  logic [PID_W-1:0] ctx_pid = '0;
  logic quota_wr = 1'b0;
  logic [PID_W-1:0] quota_pid = '0;
  logic [CNT_W-1:0] quota_val = '0;
  logic quota_err;

  lpl_victim_sel #(.LINES(LINES), .PROCS(PROCS), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_line(rsp_line),
    .rsp_evict(rsp_evict), .rsp_evict_pid(rsp_evict_pid), .ctx_switch(ctx_switch),
    .ctx_pid(ctx_pid), .active_pid(active_pid), .quota_wr(quota_wr), .quota_pid(quota_pid),
    .quota_val(quota_val), .quota_err(quota_err)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    bit    hit;
    int    line;
    bit    ev;
    int    evp;
    string req;
  } exp_t;
  exp_t expq[$];
  exp_t mon_e;

  // Reference model state
  bit m_valid[LINES];
  int m_owner[LINES];
  int m_tag[LINES];
  int m_rank[LINES];
  int m_quota[PROCS];
  int m_held[PROCS];
  int m_act;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int m_count(input int p);
    int c = 0;
    for (int i = 0; i < LINES; i++) if (m_valid[i] && m_owner[i] == p) c++;
    return c;
  endfunction

  function automatic int m_pos(input int i);
    int c = 0;
    for (int j = 0; j < LINES; j++)
      if (m_valid[j] && m_owner[j] == m_owner[i] && m_rank[j] < m_rank[i]) c++;
    return c;
  endfunction

  function automatic int m_eff(input int p);
    return (m_quota[p] < m_held[p]) ? m_quota[p] : m_held[p];
  endfunction

  function automatic int m_lru(input int mode);
    int best = -1;
    for (int i = 0; i < LINES; i++) begin
      bit sel;
      if (mode == 1)      sel = m_valid[i] && m_owner[i] != m_act && m_pos(i) >= m_eff(m_owner[i]);
      else if (mode == 2) sel = m_valid[i] && m_owner[i] == m_act;
      else                sel = m_valid[i];
      if (sel && (best < 0 || m_rank[i] > m_rank[best])) best = i;
    end
    return best;
  endfunction

  task automatic m_access(input int tag, input string lbl);
    exp_t  e;
    int    v = -1;
    int    old;
    string path;
    e.hit = 0;
    for (int i = 0; i < LINES; i++)
      if (m_valid[i] && m_tag[i] == tag && m_owner[i] == m_act) begin e.hit = 1; v = i; end
    if (e.hit) path = "R1";
    else begin
      for (int i = LINES - 1; i >= 0; i--) if (!m_valid[i]) v = i;
      if (v >= 0) path = "R2";
      else begin
        v = m_lru(1);
        if (v >= 0) path = "R3 R11";
        else begin
          v = m_lru(2);
          if (v < 0) v = m_lru(3);
          path = "R5 R11";
        end
      end
    end
    e.line = v;
    e.ev   = !e.hit && m_valid[v];
    e.evp  = e.ev ? m_owner[v] : 0;
    e.req  = (lbl == "") ? path : lbl;
    expq.push_back(e);
    if (!e.hit) begin m_valid[v] = 1; m_owner[v] = m_act; m_tag[v] = tag; end
    old = m_rank[v];
    for (int i = 0; i < LINES; i++) if (m_rank[i] < old) m_rank[i]++;
    m_rank[v] = 0;
  endtask

  // Monitor: compare every delivered response with the scoreboard.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (expq.size() == 0) check(1'b0, "R8", "unexpected response", 1, 0);
      else begin
        mon_e = expq.pop_front();
        check(rsp_hit == mon_e.hit, mon_e.req, "hit", int'(rsp_hit), int'(mon_e.hit));
        check(int'(rsp_line) == mon_e.line, mon_e.req, "line", int'(rsp_line), mon_e.line);
        check(rsp_evict == mon_e.ev, mon_e.req, "evict", int'(rsp_evict), int'(mon_e.ev));
        if (mon_e.ev)
          check(int'(rsp_evict_pid) == mon_e.evp, mon_e.req, "evict pid",
                int'(rsp_evict_pid), mon_e.evp);
      end
    end
  end

  task automatic do_access(input int tag, input string lbl);
    @(negedge clk);
    m_access(tag, lbl);
    req_valid = 1'b1;
    req_tag   = TAG_W'(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_ctx(input int p);
    @(negedge clk);
    ctx_switch = 1'b1;
    ctx_pid    = PID_W'(p);
    m_held[m_act] = m_count(m_act);
    m_act = p;
    @(negedge clk);
    ctx_switch = 1'b0;
    check(int'(active_pid) == p, "R9", "active pid", int'(active_pid), p);
  endtask

  task automatic do_access_ctx(input int tag, input int p, input string lbl);
    int cnt;
    @(negedge clk);
    cnt = m_count(m_act);
    m_access(tag, lbl);
    m_held[m_act] = cnt;
    m_act = p;
    req_valid  = 1'b1;
    req_tag    = TAG_W'(tag);
    ctx_switch = 1'b1;
    ctx_pid    = PID_W'(p);
    @(negedge clk);
    req_valid  = 1'b0;
    ctx_switch = 1'b0;
    check(int'(active_pid) == p, "R9", "active pid after shared cycle", int'(active_pid), p);
  endtask

  task automatic do_quota(input int p, input int val, input bit busy, input int busy_tag);
    int sum = 0;
    bit ok;
    @(negedge clk);
    for (int q = 0; q < PROCS; q++) sum += (q == p) ? val : m_quota[q];
    ok = !busy && sum <= LINES;
    if (busy) begin
      m_access(busy_tag, "");
      req_valid = 1'b1;
      req_tag   = TAG_W'(busy_tag);
    end
    quota_wr  = 1'b1;
    quota_pid = PID_W'(p);
    quota_val = CNT_W'(val);
    @(negedge clk);
    quota_wr  = 1'b0;
    req_valid = 1'b0;
    if (ok) m_quota[p] = val;
    check(quota_err == !ok, "R7", "quota_err", int'(quota_err), int'(!ok));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog expired: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [IDX_W-1:0] held_line;
    for (int i = 0; i < LINES; i++) begin
      m_valid[i] = 0; m_owner[i] = 0; m_tag[i] = 0; m_rank[i] = i;
    end
    for (int p = 0; p < PROCS; p++) begin m_quota[p] = 0; m_held[p] = 0; end
    m_act = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(rsp_valid == 1'b0, "R10", "rsp_valid", int'(rsp_valid), 0);
    check(req_ready == 1'b1, "R10", "req_ready", int'(req_ready), 1);
    check(active_pid == '0, "R10", "active_pid", int'(active_pid), 0);
    check(quota_err == 1'b0, "R10", "quota_err", int'(quota_err), 0);

    // R2: fill empty lines in index order
    for (int t = 0; t < LINES; t++) do_access(10 + t, "R2");
    do_access(10, "R1");                 // hit line 0, makes it newest
    do_ctx(1);
    do_access(20, "R6");                 // LRU of P0 is now line 1, not line 0
    do_quota(0, 3, 1'b0, 0);             // accepted
    do_quota(1, 6, 1'b0, 0);             // sum 9 > 8, R7 refused
    do_quota(1, 5, 1'b0, 0);             // sum 8, accepted
    for (int t = 21; t < 25; t++) do_access(t, "R3 R11");
    do_access(25, "R4");                 // P0 keeps its 3 newest, fallback to P1
    do_ctx(0);
    do_access(10, "R1");                 // P0 line survived while dormant
    do_access(20, "R1");                 // same tag, other owner: miss
    do_quota(2, 0, 1'b1, 11);            // write during access: R7 refused
    do_access_ctx(30, 2, "R9");          // served for outgoing P0
    do_access(30, "R9");                 // P2 lookup must miss
    do_ctx(0);
    do_access(30, "R9");                 // P0 hits again

    // R8 backpressure
    @(negedge clk);
    rsp_ready = 1'b0;
    m_access(31, "R8");
    req_valid = 1'b1;
    req_tag   = TAG_W'(31);
    @(negedge clk);
    req_valid = 1'b0;
    held_line = rsp_line;
    check(rsp_valid == 1'b1, "R8", "rsp_valid next cycle", int'(rsp_valid), 1);
    check(req_ready == 1'b0, "R8", "req_ready during stall", int'(req_ready), 0);
    @(negedge clk);
    check(rsp_valid == 1'b1, "R8", "rsp_valid held", int'(rsp_valid), 1);
    check(rsp_line == held_line, "R8", "rsp_line held", int'(rsp_line), int'(held_line));
    @(posedge clk);
    #2 rsp_ready = 1'b1;
    @(negedge clk);

    // Mixed random traffic against the model
    lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      int op;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = int'(lfsr[3:0]);
      if (op < 11)      do_access(40 + int'(lfsr[7:4]) % 12, "");
      else if (op < 13) do_ctx(int'(lfsr[9:8]));
      else if (op < 14) do_quota(int'(lfsr[9:8]), int'(lfsr[6:4]) % 4, lfsr[11], 40 + int'(lfsr[7:4]) % 12);
      else              do_access_ctx(40 + int'(lfsr[7:4]) % 12, int'(lfsr[9:8]), "R9");
    end

    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R8", "responses outstanding", expq.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule